// File: doc/BRIEF.md
# I2C Register-Bank Target with Auto-Increment

This block is an I2C target that gives an external bus controller access to a bank of sixteen 8-bit control registers. It watches the bus through synchronizers clocked by the system clock, finds START, repeated START and STOP conditions, and answers only to its fixed device address. The first byte after a write address selects the register pointer. Any further bytes are stored at that pointer, and the pointer steps forward after each one.

A read sets the pointer with a write transaction. The controller then issues a repeated START with the read address and clocks data out of the bank. Every controller ACK moves the pointer on by one. A NACK leaves the pointer where it is and ends the transfer. Each register can be read back either from its own stored value or from a separate status input, selected per register by a parameter mask. Every write also appears on a parallel strobe/address/data port, so neighbouring logic can follow updates.

Top module: `i2c_regbank_target`

## Requirements
- R1: After reset, SDA is released (`sda_oe_o`=0), no write strobe is issued, and every stored register reads 0x00 on `regs_o` (register i in bits 8i+7..8i).
- R2: The target acknowledges, by pulling SDA low during the ninth clock, an address byte whose upper seven bits are 1110010. Bit 0 of that byte selects the direction: 0 is write and 1 is read.
- R3: An address byte with any other upper seven bits gets no ACK. SDA then stays released and no register is written until the next START.
- R4: After a write address, the next byte is acknowledged and its low 4 bits load the register pointer. Its upper 4 bits are ignored.
- R5: Every later byte in a write transaction is acknowledged. It is written to the pointer location with a single one-cycle pulse on `wr_stb_o`, and the pointer then advances by one, wrapping from 15 to 0.
- R6: After a repeated START with a read address, the target drives the byte at the pointer MSB first. It changes SDA only while SCL is low, and it releases SDA during the acknowledge clock.
- R7: A controller ACK after a read byte advances the pointer by one and starts the next byte. A NACK leaves the pointer unchanged, so a later read without a new pointer byte returns the same register. It also ends the transfer.
- R8: Registers whose bit is set in `STATUS_MASK` (default: registers 14 and 15) return the matching byte of `status_i` on reads. All other registers return their stored value. A write to a status-mapped register still updates its stored value on `regs_o`.
- R9: The sequence START, nine clocks with SDA high, repeated START, STOP returns the target to idle from any point. It leaves every register unchanged, including when it cuts a data byte short, and the next transaction works normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x the SCL rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Raw SCL level from the bus |
| sda_i | input | 1 | Raw SDA level from the bus |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| status_i | input | NREG*8 | Read data for status-mapped registers, register i in bits 8i+7..8i |
| wr_stb_o | output | 1 | One-cycle pulse per register write |
| wr_addr_o | output | ADDR_W | Register index of the write |
| wr_data_o | output | 8 | Data of the write |
| regs_o | output | NREG*8 | Stored contents of all registers |

## Verification
The bench builds the block with its default parameters: sixteen registers, device address 1110010, status mask 0xC000 and two synchronizer stages. SCL runs at one thirty-second of the system clock. With sixteen registers, a three-byte burst starting at pointer 14 crosses the 15-to-0 wrap. With the mask at 0xC000, the two status-mapped registers sit right next to that wrap, so one burst read covers a stored register followed by both status sources. The slow SCL gives the two-stage synchronizer and edge detector room to drive the ACK and the data bits within the low phase, with the bus modelled as a wired-AND of the controller and the target.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ADDR = 3'd1,
    PH_PTR  = 3'd2,
    PH_WR   = 3'd3,
    PH_RD   = 3'd4
  } phase_t;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/i2c_rb_busmon.sv
module i2c_rb_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o,
  output logic sda_s_o
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] scl_sync_q, sda_sync_q;
  logic         scl_prev_q, sda_prev_q;
  logic         scl_s, sda_s;

  // bus lines idle high, so synchronizers reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync_q <= '1;
      sda_sync_q <= '1;
      scl_prev_q <= 1'b1;
      sda_prev_q <= 1'b1;
    end else begin
      scl_sync_q <= {scl_sync_q[TOP-1:0], scl_i};
      sda_sync_q <= {sda_sync_q[TOP-1:0], sda_i};
      scl_prev_q <= scl_s;
      sda_prev_q <= sda_s;
    end
  end

  assign scl_s = scl_sync_q[TOP];
  assign sda_s = sda_sync_q[TOP];

  assign scl_rise_o = scl_s & ~scl_prev_q;
  assign scl_fall_o = ~scl_s & scl_prev_q;
  // SDA edges while SCL is steadily high are bus conditions
  assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
  assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
  assign sda_s_o    = sda_s;
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
  import i2c_rb_pkg::*;
#(
  parameter int         ADDR_W   = 4,
  parameter logic [6:0] DEV_ADDR = 7'b1110010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise_i,
  input  logic              scl_fall_i,
  input  logic              start_i,
  input  logic              stop_i,
  input  logic              sda_s_i,
  input  logic [7:0]        rd_data_i,
  output logic              sda_oe_o,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o
);
  localparam logic [3:0] LAST_BIT  = 4'(BYTE_W - 1);
  localparam logic [3:0] BYTE_BITS = 4'(BYTE_W);

  phase_t            phase_q, phase_d;
  logic [3:0]        cnt_q, cnt_d;
  logic [7:0]        sh_q, sh_d;
  logic              in_ack_q, in_ack_d;
  logic              pend_q, pend_d;
  logic              rw_q, rw_d;
  logic              oe_q, oe_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d;
  logic              wstb_q, wstb_d;
  logic [ADDR_W-1:0] waddr_q, waddr_d;
  logic [7:0]        wdata_q, wdata_d;
  logic [7:0]        byte_v;

  always_comb begin
    phase_d  = phase_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    in_ack_d = in_ack_q;
    pend_d   = pend_q;
    rw_d     = rw_q;
    oe_d     = oe_q;
    ptr_d    = ptr_q;
    wstb_d   = 1'b0;
    waddr_d  = waddr_q;
    wdata_d  = wdata_q;
    byte_v   = {sh_q[6:0], sda_s_i};

    if (stop_i) begin
      phase_d  = PH_IDLE;
      oe_d     = 1'b0;
      in_ack_d = 1'b0;
      pend_d   = 1'b0;
    end else if (start_i) begin
      phase_d  = PH_ADDR;
      cnt_d    = '0;
      oe_d     = 1'b0;
      in_ack_d = 1'b0;
      pend_d   = 1'b0;
    end else begin
      case (phase_q)
        PH_ADDR, PH_PTR, PH_WR: begin
          if (scl_rise_i && !in_ack_q && !pend_q) begin
            sh_d  = byte_v;
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              cnt_d = '0;
              if (phase_q == PH_ADDR) begin
                if (byte_v[7:1] == DEV_ADDR) begin
                  pend_d = 1'b1;
                  rw_d   = byte_v[0];
                end else begin
                  phase_d = PH_IDLE;
                end
              end else if (phase_q == PH_PTR) begin
                ptr_d  = byte_v[ADDR_W-1:0];
                pend_d = 1'b1;
              end else begin
                // commit at the eighth bit, before the ACK clock
                wstb_d  = 1'b1;
                waddr_d = ptr_q;
                wdata_d = byte_v;
                ptr_d   = ptr_q + 1'b1;
                pend_d  = 1'b1;
              end
            end
          end else if (scl_fall_i && pend_q) begin
            oe_d     = 1'b1;
            in_ack_d = 1'b1;
            pend_d   = 1'b0;
          end else if (scl_fall_i && in_ack_q) begin
            in_ack_d = 1'b0;
            oe_d     = 1'b0;
            cnt_d    = '0;
            if (phase_q == PH_ADDR) begin
              if (rw_q) begin
                phase_d = PH_RD;
                sh_d    = rd_data_i;
                oe_d    = ~rd_data_i[7];
              end else begin
                phase_d = PH_PTR;
              end
            end else begin
              phase_d = PH_WR;
            end
          end
        end
        PH_RD: begin
          if (!in_ack_q) begin
            if (scl_rise_i) begin
              cnt_d = cnt_q + 1'b1;
              sh_d  = {sh_q[6:0], 1'b0};
            end else if (scl_fall_i) begin
              if (cnt_q == BYTE_BITS) begin
                oe_d     = 1'b0;
                in_ack_d = 1'b1;
                cnt_d    = '0;
              end else if (cnt_q != '0) begin
                oe_d = ~sh_q[7];
              end
            end
          end else begin
            if (scl_rise_i && !pend_q) begin
              if (!sda_s_i) begin
                ptr_d  = ptr_q + 1'b1;
                pend_d = 1'b1;
              end else begin
                phase_d  = PH_IDLE;
                in_ack_d = 1'b0;
              end
            end else if (scl_fall_i && pend_q) begin
              sh_d     = rd_data_i;
              oe_d     = ~rd_data_i[7];
              in_ack_d = 1'b0;
              pend_d   = 1'b0;
              cnt_d    = '0;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      in_ack_q <= 1'b0;
      pend_q   <= 1'b0;
      rw_q     <= 1'b0;
      oe_q     <= 1'b0;
      ptr_q    <= '0;
      wstb_q   <= 1'b0;
      waddr_q  <= '0;
      wdata_q  <= '0;
    end else begin
      phase_q  <= phase_d;
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      in_ack_q <= in_ack_d;
      pend_q   <= pend_d;
      rw_q     <= rw_d;
      oe_q     <= oe_d;
      ptr_q    <= ptr_d;
      wstb_q   <= wstb_d;
      waddr_q  <= waddr_d;
      wdata_q  <= wdata_d;
    end
  end

  assign sda_oe_o  = oe_q;
  assign ptr_o     = ptr_q;
  assign wr_stb_o  = wstb_q;
  assign wr_addr_o = waddr_q;
  assign wr_data_o = wdata_q;

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_IDLE) |-> !oe_q); // R3
  AST_SDA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_fall_i && !start_i && !stop_i) |=> $stable(oe_q)); // R6
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_q |=> !wstb_q); // R5
  AST_WR_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wstb_q |-> (ptr_q == ADDR_W'(waddr_q + 1'b1))); // R5
  AST_NACK_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RD && in_ack_q && !pend_q && scl_rise_i && sda_s_i) |=> $stable(ptr_q)); // R7
endmodule

// File: rtl/i2c_rb_regfile.sv
module i2c_rb_regfile #(
  parameter int                NREG        = 16,
  parameter int                ADDR_W      = 4,
  parameter logic [NREG-1:0]   STATUS_MASK = 16'hC000,
  parameter logic [NREG*8-1:0] REG_INIT    = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [NREG*8-1:0] status_i,
  output logic [7:0]        rd_data_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [7:0] rd_vec [NREG];

  for (genvar g = 0; g < NREG; g++) begin : gen_reg
    logic [7:0] q;
    logic       hit;

    assign hit = wr_stb_i && (wr_addr_i == ADDR_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= REG_INIT[g*8 +: 8];
      else if (hit) q <= wr_data_i;
    end

    assign regs_o[g*8 +: 8] = q;

    if (STATUS_MASK[g]) begin : gen_status
      assign rd_vec[g] = status_i[g*8 +: 8];
    end else begin : gen_stored
      assign rd_vec[g] = q;
    end
  end

  assign rd_data_o = rd_vec[rd_addr_i];
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
  parameter int                NREG        = 16,
  parameter logic [6:0]        DEV_ADDR    = 7'b1110010,
  parameter logic [NREG-1:0]   STATUS_MASK = 16'hC000,
  parameter logic [NREG*8-1:0] REG_INIT    = '0,
  parameter int                SYNC_STAGES = 2,
  localparam int               ADDR_W      = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic [NREG*8-1:0] status_i,
  output logic              wr_stb_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic [NREG*8-1:0] regs_o
);
  logic [1:0]        rst_pipe_q;
  logic              rst_n_int;
  logic              scl_rise, scl_fall, bus_start, bus_stop, sda_s;
  logic [7:0]        rd_data;
  logic [ADDR_W-1:0] ptr;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_int = rst_pipe_q[1];

  i2c_rb_busmon #(.SYNC_STAGES(SYNC_STAGES)) busmon_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (bus_start),
    .stop_o     (bus_stop),
    .sda_s_o    (sda_s)
  );

  i2c_rb_engine #(.ADDR_W(ADDR_W), .DEV_ADDR(DEV_ADDR)) engine_i (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .start_i    (bus_start),
    .stop_i     (bus_stop),
    .sda_s_i    (sda_s),
    .rd_data_i  (rd_data),
    .sda_oe_o   (sda_oe_o),
    .ptr_o      (ptr),
    .wr_stb_o   (wr_stb_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o)
  );

  i2c_rb_regfile #(
    .NREG(NREG), .ADDR_W(ADDR_W), .STATUS_MASK(STATUS_MASK), .REG_INIT(REG_INIT)
  ) regfile_i (
    .clk       (clk),
    .rst_n     (rst_n_int),
    .wr_stb_i  (wr_stb_o),
    .wr_addr_i (wr_addr_o),
    .wr_data_i (wr_data_o),
    .rd_addr_i (ptr),
    .status_i  (status_i),
    .rd_data_o (rd_data),
    .regs_o    (regs_o)
  );
endmodule

// File: tb/i2c_regbank_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regbank_target_tb_top;
  localparam int Q = 40;                 // quarter SCL period, ns
  localparam logic [15:0] SMASK = 16'hC000;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         scl_m, sda_m;
  logic         sda_bus;
  logic         sda_oe_o;
  logic [127:0] status_v;
  logic         wr_stb_o;
  logic [3:0]   wr_addr_o;
  logic [7:0]   wr_data_o;
  logic [127:0] regs_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [11:0] exp_q [$];
  logic [7:0]  model [16];
  logic [7:0]  wbuf  [8];

  always #2.5 clk = ~clk;

  assign sda_bus = sda_m & ~sda_oe_o;

  i2c_regbank_target dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_m),
    .sda_i     (sda_bus),
    .sda_oe_o  (sda_oe_o),
    .status_i  (status_v),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .regs_o    (regs_o)
  );

  task automatic chk(input bit ok, input string what, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [127:0] model_vec();
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] rd_model(input int a);
    return SMASK[a] ? status_v[a*8 +: 8] : model[a];
  endfunction

  // scoreboard monitor for the write port
  always @(negedge clk) begin
    if (rst_n && wr_stb_o) begin
      if (exp_q.size() == 0) begin
        n_chk++;
        n_bad++;
        $display("FAIL R3/R9 unexpected write: actual=%0h/%0h expected=none", wr_addr_o, wr_data_o);
      end else begin
        logic [11:0] e;
        e = exp_q.pop_front();
        chk({wr_addr_o, wr_data_o} == e, "R5 write port item", {wr_addr_o, wr_data_o}, e);
      end
    end
  end

  task automatic push_wr(input logic [3:0] a, input logic [7:0] d);
    exp_q.push_back({a, d});
    model[a] = d;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; sda_m = 1'b0; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #Q; scl_m = 1'b1; #Q; sda_m = 1'b1; #(2*Q);
  endtask

  task automatic bit_tx(input logic b);
    sda_m = b; #Q; scl_m = 1'b1; #(2*Q); scl_m = 1'b0; #Q;
  endtask

  task automatic bit_rx(output logic b);
    sda_m = 1'b1; #Q; scl_m = 1'b1; #Q; b = sda_bus; #Q; scl_m = 1'b0; #Q;
  endtask

  task automatic byte_tx(input logic [7:0] v, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_tx(v[i]);
    bit_rx(b);
    ack = ~b;
  endtask

  task automatic byte_rx(input logic mack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      bit_rx(b);
      v[i] = b;
    end
    bit_tx(~mack);
  endtask

  // write transaction: address, pointer byte, n bytes from wbuf
  task automatic wr_txn(input logic [7:0] ptr_b, input int n);
    logic       ack;
    logic [3:0] p;
    p = ptr_b[3:0];
    bus_start();
    byte_tx(8'hE4, ack);
    chk(ack == 1'b1, "R2 write address ACK", ack, 1);
    byte_tx(ptr_b, ack);
    chk(ack == 1'b1, "R4 pointer byte ACK", ack, 1);
    for (int k = 0; k < n; k++) begin
      push_wr(p, wbuf[k]);
      byte_tx(wbuf[k], ack);
      chk(ack == 1'b1, "R5 data byte ACK", ack, 1);
      p = p + 4'd1;
    end
    bus_stop();
  endtask

  // pointer write, repeated START, read address
  task automatic rd_open(input logic [7:0] ptr_b);
    logic ack;
    bus_start();
    byte_tx(8'hE4, ack);
    chk(ack == 1'b1, "R2 address ACK before read", ack, 1);
    byte_tx(ptr_b, ack);
    chk(ack == 1'b1, "R4 pointer ACK before read", ack, 1);
    bus_start();
    byte_tx(8'hE5, ack);
    chk(ack == 1'b1, "R6 read address ACK", ack, 1);
  endtask

  initial begin
    logic       ack;
    logic [7:0] v;
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    for (int i = 0; i < 16; i++) begin
      model[i] = 8'h00;
      status_v[i*8 +: 8] = 8'h55;
    end
    status_v[14*8 +: 8] = 8'h3C;
    status_v[15*8 +: 8] = 8'hE7;
    #100;
    rst_n = 1'b1;
    #100;

    // R1 reset state
    chk(sda_oe_o == 1'b0, "R1 SDA released after reset", sda_oe_o, 0);
    chk(wr_stb_o == 1'b0, "R1 no write strobe after reset", wr_stb_o, 0);
    chk(regs_o == model_vec(), "R1 registers zero after reset", regs_o, model_vec());

    // R4 upper nibble ignored, R5 burst
    wbuf[0] = 8'h5A; wbuf[1] = 8'hC3;
    wr_txn(8'hA3, 2);
    #200;
    chk(regs_o[3*8 +: 8] == 8'h5A, "R4 pointer 0xA3 selects register 3", regs_o[3*8 +: 8], 8'h5A);
    chk(regs_o == model_vec(), "R5 bank after burst", regs_o, model_vec());

    // R5 wrap 14,15,0
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    wr_txn(8'h0E, 3);
    #200;
    chk(regs_o[0 +: 8] == 8'h33, "R5 pointer wraps 15 to 0", regs_o[0 +: 8], 8'h33);

    // R3 mismatched write address then bytes
    bus_start();
    byte_tx(8'hE6, ack);
    chk(ack == 1'b0, "R3 foreign write address not ACKed", ack, 0);
    byte_tx(8'h01, ack);
    chk(ack == 1'b0, "R3 byte after foreign address not ACKed", ack, 0);
    byte_tx(8'h77, ack);
    chk(ack == 1'b0, "R3 second byte not ACKed", ack, 0);
    bus_stop();
    // R3 mismatched read address: SDA must stay released
    bus_start();
    byte_tx(8'hE7, ack);
    chk(ack == 1'b0, "R3 foreign read address not ACKed", ack, 0);
    byte_rx(1'b0, v);
    chk(v == 8'hFF, "R3 SDA released after foreign read", v, 8'hFF);
    bus_stop();
    #200;
    chk(regs_o == model_vec(), "R3 registers untouched", regs_o, model_vec());

    // R6/R7 read burst from 3: ACK then NACK
    rd_open(8'h03);
    byte_rx(1'b1, v);
    chk(v == model[3], "R6 first read byte", v, model[3]);
    byte_rx(1'b0, v);
    chk(v == model[4], "R7 ACK advanced pointer", v, model[4]);
    bus_stop();
    chk(sda_oe_o == 1'b0, "R7 SDA released after NACK", sda_oe_o, 0);

    // R7 NACK held pointer at 4
    bus_start();
    byte_tx(8'hE5, ack);
    chk(ack == 1'b1, "R6 direct read address ACK", ack, 1);
    byte_rx(1'b0, v);
    chk(v == model[4], "R7 pointer held after NACK", v, model[4]);
    bus_stop();

    // R8 status sources at 14, 15
    rd_open(8'h0D);
    byte_rx(1'b1, v);
    chk(v == rd_model(13), "R8 stored register 13", v, rd_model(13));
    byte_rx(1'b1, v);
    chk(v == 8'h3C, "R8 status register 14", v, 8'h3C);
    byte_rx(1'b0, v);
    chk(v == 8'hE7, "R8 status register 15", v, 8'hE7);
    bus_stop();
    chk(regs_o[14*8 +: 8] == 8'h11, "R8 stored value of status register kept", regs_o[14*8 +: 8], 8'h11);

    // R9 recovery mid data byte
    bus_start();
    byte_tx(8'hE4, ack);
    byte_tx(8'h05, ack);
    bit_tx(1'b1); bit_tx(1'b0); bit_tx(1'b1); bit_tx(1'b0);
    bus_start();
    for (int i = 0; i < 9; i++) bit_tx(1'b1);
    bus_start();
    bus_stop();
    #200;
    chk(regs_o == model_vec(), "R9 recovery left registers intact", regs_o, model_vec());
    chk(sda_oe_o == 1'b0, "R9 SDA released after recovery", sda_oe_o, 0);
    wbuf[0] = 8'h9C;
    wr_txn(8'h07, 1);
    #200;
    chk(regs_o[7*8 +: 8] == 8'h9C, "R9 write works after recovery", regs_o[7*8 +: 8], 8'h9C);

    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #800000;
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule